// File: doc/BRIEF.md
# Radio Status Interrupt Controller

This block gathers four radio status events into a single interrupt and presents it on a data-line output whose active level is programmable. Three sources are derived inside the block from status levels: a stereo-indication input raises an event on any change, a field-strength indication input raises an event on any change, and a frequency-error input raises an event when it goes out of range. The fourth source is a done strobe from a measurement counter. Each event latches a sticky pending flag, whatever its mask says.

The host writes a configuration byte that holds one enable per source and a polarity bit. The interrupt is active while any pending flag has its enable set. The data-line output carries the interrupt at the chosen level and rests at the opposite level otherwise. A separate drive-permission input from the serial bus side decides when the output buffer is enabled. A host clear pulse empties all pending flags. An event in the same cycle as the clear is not lost.

Top module: `radio_irq_ctrl`

## Requirements
- R1: While rst_ni is low and after reset, all pending flags, enables and the polarity bit are 0, so irq_o and line_o are 0.
- R2: A write (cfg_we_i high at a clock edge) loads the enables from cfg_wdata_i: bit 0 counter done, bit 1 field strength, bit 2 frequency error, bit 6 stereo, and polarity from bit 3. Bits 7, 5 and 4 have no effect.
- R3: Any change of stereo_i between consecutive clock samples sets the stereo pending flag at that edge.
- R4: Any change of fs_i between consecutive clock samples sets the field-strength pending flag at that edge.
- R5: A rising edge of afc_oor_i sets the frequency-error pending flag. A falling edge does not.
- R6: cnt2_done_i sampled high at a clock edge sets the counter pending flag.
- R7: Pending flags latch while their enable is 0 and hold until cleared. Enabling a source later with its flag already set raises irq_o.
- R8: irq_o is high exactly when at least one pending flag has its enable set.
- R9: clr_i high at an edge empties all pending flags, except a flag whose event occurs in that same cycle, which is set.
- R10: line_o equals irq_o when the polarity bit is 0 and its inverse when the polarity bit is 1.
- R11: line_oe_o follows drive_en_i in the same cycle, whatever the interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| stereo_i | input | 1 | Stereo indication level |
| afc_oor_i | input | 1 | Frequency error out-of-range level |
| fs_i | input | 1 | Field-strength indication level |
| cnt2_done_i | input | 1 | Measurement counter done strobe |
| clr_i | input | 1 | Clear all pending flags |
| drive_en_i | input | 1 | Data-line drive permission |
| irq_o | output | 1 | Interrupt active, active high |
| line_o | output | 1 | Data-line value at programmed polarity |
| line_oe_o | output | 1 | Data-line output enable |

## Verification
Two functions can fall in the same cycle: the host clear and a new event from any of the four sources. The bench raises clr_i in the same cycle that it toggles the stereo and field-strength inputs and while the counter strobe is held high. It then checks that those flags survive and that the other flags are emptied. A behavioural model keeps the pending set as an integer and compares irq_o, line_o and line_oe_o against it every clock. A configuration write in the same cycle as an event is also covered. The bench expects the event to latch and the new enable to apply at that edge.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
  localparam int unsigned NSRC  = 4;
  localparam int unsigned CFG_W = 8;
  localparam int unsigned POL_BIT = 3;

  localparam int unsigned SRC_CNT2 = 0;
  localparam int unsigned SRC_FS   = 1;
  localparam int unsigned SRC_AFC  = 2;
  localparam int unsigned SRC_ST   = 3;

  typedef enum logic [1:0] {
    DET_LEVEL  = 2'd0,
    DET_RISE   = 2'd1,
    DET_TOGGLE = 2'd2
  } det_kind_e;

  function automatic det_kind_e src_kind(int unsigned idx);
    case (idx)
      SRC_CNT2: return DET_LEVEL;
      SRC_AFC:  return DET_RISE;
      default:  return DET_TOGGLE;
    endcase
  endfunction

  // config bit position of each source enable
  function automatic int unsigned en_bit(int unsigned idx);
    case (idx)
      SRC_CNT2: return 0;
      SRC_FS:   return 1;
      SRC_AFC:  return 2;
      default:  return 6;
    endcase
  endfunction

  function automatic logic [CFG_W-1:0] used_bits();
    logic [CFG_W-1:0] m;
    m = '0;
    m[POL_BIT] = 1'b1;
    for (int unsigned i = 0; i < NSRC; i++) m[en_bit(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/radio_irq_evdet.sv
module radio_irq_evdet
  import radio_irq_pkg::*;
#(
  parameter det_kind_e KIND = DET_TOGGLE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic ev_o
);
  generate
    if (KIND == DET_LEVEL) begin : g_level
      assign ev_o = sig_i;
    end else begin : g_edge
      logic sig_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sig_q <= 1'b0;
        else         sig_q <= sig_i;
      end
      if (KIND == DET_RISE) begin : g_rise
        assign ev_o = sig_i & ~sig_q;
      end else begin : g_tog
        assign ev_o = sig_i ^ sig_q;
      end
    end
  endgenerate
endmodule

// File: rtl/radio_irq_cfg.sv
module radio_irq_cfg
  import radio_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [NSRC-1:0]  en_o,
  output logic             pol_o
);
  localparam logic [CFG_W-1:0] USED = used_bits();

  logic [NSRC-1:0] en_d;
  logic            unused_rsv;

  assign unused_rsv = ^(wdata_i & ~USED);

  for (genvar i = 0; i < NSRC; i++) begin : g_map
    assign en_d[i] = wdata_i[en_bit(i)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= '0;
      pol_o <= 1'b0;
    end else if (we_i) begin
      en_o  <= en_d;
      pol_o <= wdata_i[POL_BIT];
    end
  end
endmodule

// File: rtl/radio_irq_pend.sv
module radio_irq_pend
  import radio_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] ev_i,
  input  logic            clr_i,
  output logic [NSRC-1:0] pend_o
);
  // new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (clr_i ? '0 : pend_o) | ev_i;
  end
endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
  import radio_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic             stereo_i,
  input  logic             afc_oor_i,
  input  logic             fs_i,
  input  logic             cnt2_done_i,
  input  logic             clr_i,
  input  logic             drive_en_i,
  output logic             irq_o,
  output logic             line_o,
  output logic             line_oe_o
);
  logic [NSRC-1:0] src_lvl;
  logic [NSRC-1:0] ev;
  logic [NSRC-1:0] pend_q;
  logic [NSRC-1:0] en_q;
  logic            pol_q;

  assign src_lvl[SRC_CNT2] = cnt2_done_i;
  assign src_lvl[SRC_FS]   = fs_i;
  assign src_lvl[SRC_AFC]  = afc_oor_i;
  assign src_lvl[SRC_ST]   = stereo_i;

  for (genvar i = 0; i < NSRC; i++) begin : g_det
    radio_irq_evdet #(.KIND(src_kind(i))) u_det (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (src_lvl[i]),
      .ev_o  (ev[i])
    );
  end

  radio_irq_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .en_o   (en_q),
    .pol_o  (pol_q)
  );

  radio_irq_pend u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (ev),
    .clr_i (clr_i),
    .pend_o(pend_q)
  );

  assign irq_o     = |(pend_q & en_q);
  assign line_o    = irq_o ^ pol_q;
  assign line_oe_o = drive_en_i;
endmodule

// File: rtl/radio_irq_ctrl_chk.sv
module radio_irq_ctrl_chk
  import radio_irq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            clr_i,
  input logic            drive_en_i,
  input logic            afc_oor_i,
  input logic [NSRC-1:0] ev,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] en_q,
  input logic            pol_q,
  input logic            irq_o,
  input logic            line_o,
  input logic            line_oe_o
);
  AST_RESET_EMPTY: assert property (@(posedge clk_i) !rst_ni |-> (pend_q == '0 && !irq_o)) else $error("AST_RESET_EMPTY"); // R1
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> ((pend_q & $past(pend_q)) == $past(pend_q))) else $error("AST_STICKY"); // R7
  AST_EVENT_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev != '0) |=> ((pend_q & $past(ev)) == $past(ev))) else $error("AST_EVENT_LATCH"); // R9
  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ev == '0) |=> (pend_q == '0)) else $error("AST_CLEAR_EMPTY"); // R9
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend_q & en_q) != '0)) else $error("AST_IRQ_NEEDS_EN"); // R8
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (line_o == pol_q)) else $error("AST_IDLE_LEVEL"); // R10
  AST_AFC_FALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(afc_oor_i) |-> !ev[SRC_AFC]) else $error("AST_AFC_FALL_QUIET"); // R5
  AST_OE_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_oe_o == drive_en_i) else $error("AST_OE_FOLLOW"); // R11
endmodule

bind radio_irq_ctrl radio_irq_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .drive_en_i(drive_en_i),
  .afc_oor_i (afc_oor_i),
  .ev        (ev),
  .pend_q    (pend_q),
  .en_q      (en_q),
  .pol_q     (pol_q),
  .irq_o     (irq_o),
  .line_o    (line_o),
  .line_oe_o (line_oe_o)
);

// File: tb/radio_irq_ctrl_bench.sv
module radio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic       st = 1'b0, afc = 1'b0, fs = 1'b0, c2 = 1'b0, clr = 1'b0, den = 1'b0;
  logic       irq, line, oe;

  int errors = 0;
  int checks = 0;
  string tag = "R1";
  bit done = 1'b0;

  // model state
  int m_pend, m_en, m_pol;
  int p_st, p_afc, p_fs;

  always #10 clk = ~clk;

  radio_irq_ctrl u_radio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_wdata_i(wdata),
    .stereo_i(st), .afc_oor_i(afc), .fs_i(fs), .cnt2_done_i(c2),
    .clr_i(clr), .drive_en_i(den),
    .irq_o(irq), .line_o(line), .line_oe_o(oe)
  );

  // behavioural reference: pending bits 0 counter, 1 fs, 2 afc, 3 stereo
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_en = 0; m_pol = 0; p_st = 0; p_afc = 0; p_fs = 0;
    end else begin
      int ev;
      ev = 0;
      if (c2) ev += 1;
      if (int'(fs) != p_fs) ev += 2;
      if (afc && p_afc == 0) ev += 4;
      if (int'(st) != p_st) ev += 8;
      if (clr) m_pend = 0;
      m_pend = m_pend | ev;
      p_st = int'(st); p_afc = int'(afc); p_fs = int'(fs);
      if (we) begin
        m_en  = int'(wdata[0]) + 2*int'(wdata[1]) + 4*int'(wdata[2]) + 8*int'(wdata[6]);
        m_pol = int'(wdata[3]);
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      int e_irq;
      e_irq = ((m_pend & m_en) != 0) ? 1 : 0;
      chk(tag, "irq_o", int'(irq), e_irq);
      chk(tag, "line_o", int'(line), e_irq ^ m_pol);
      chk(tag, "line_oe_o", int'(oe), int'(den));
    end
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic wr(logic [7:0] v);
    we = 1'b1; wdata = v; cyc(1); we = 1'b0;
  endtask

  task automatic clear();
    clr = 1'b1; cyc(1); clr = 1'b0;
  endtask

  initial begin
    cyc(3);
    chk("R1", "reset irq_o", int'(irq), 0);
    chk("R1", "reset line_o", int'(line), 0);
    #8 rst_n = 1'b1;
    cyc(2);

    tag = "R2"; // reserved bits only, all sources fire, no interrupt
    wr(8'hB0);
    c2 = 1'b1; st = 1'b1; fs = 1'b1; afc = 1'b1; cyc(1);
    c2 = 1'b0; cyc(2);
    #5 chk("R2", "reserved bits enable nothing", int'(irq), 0);
    cyc(1);
    tag = "R7";
    wr(8'h01); cyc(1); #5 chk("R7", "late enable counter", int'(irq), 1); cyc(1);
    wr(8'h02); cyc(1);
    wr(8'h04); cyc(1);
    wr(8'h40); cyc(1);
    tag = "R8"; wr(8'h00); cyc(1); #5 chk("R8", "all disabled", int'(irq), 0); cyc(1);
    clear(); wr(8'h47); cyc(1); #5 chk("R9", "cleared", int'(irq), 0); cyc(1);

    tag = "R3"; wr(8'h40);
    st = 1'b0; cyc(1); #5 chk("R3", "stereo fall", int'(irq), 1); cyc(1);
    clear(); cyc(2); st = 1'b1; cyc(2); clear(); cyc(3);

    tag = "R4"; wr(8'h02);
    fs = 1'b0; cyc(2); clear(); fs = 1'b1; cyc(2); clear(); cyc(2);

    tag = "R5"; wr(8'h04);
    afc = 1'b0; cyc(2); #5 chk("R5", "afc fall quiet", int'(irq), 0); cyc(1);
    afc = 1'b1; cyc(2); clear(); cyc(2); afc = 1'b0; cyc(3);

    tag = "R6"; wr(8'h01);
    c2 = 1'b1; cyc(1); c2 = 1'b0; cyc(2); clear(); cyc(2);

    tag = "R9"; wr(8'h4F); // all enabled, polarity low-active
    c2 = 1'b1; cyc(2);
    clr = 1'b1; cyc(1); clr = 1'b0; #5 chk("R9", "counter held through clear", int'(irq), 1); cyc(1);
    c2 = 1'b0; clear(); cyc(1);
    clr = 1'b1; st = 1'b0; fs = 1'b0; cyc(1); clr = 1'b0; cyc(2);
    we = 1'b1; wdata = 8'h01; afc = 1'b1; cyc(1); we = 1'b0; cyc(2);

    tag = "R10"; wr(8'h4F); cyc(2);
    #5 chk("R10", "active-low line", int'(line), 0); cyc(1);
    clear(); cyc(2);
    wr(8'h47); st = 1'b1; cyc(2);

    tag = "R11";
    den = 1'b1; cyc(3); clear(); cyc(2); den = 1'b0; cyc(1); den = 1'b1; cyc(2);
    #5 chk("R11", "oe with drive", int'(oe), 1);
    cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule